// File: doc/BRIEF.md
# Transcoding Burst-Correcting FEC Encoder

This block is the transmit half of a forward error correction layer for a backplane Ethernet lane. It accepts a stream of 66-bit line blocks, each holding a two-bit sync header and a 64-bit payload, and groups them into frames of 32 blocks. Each header is squeezed to a single transcode bit, so a frame shrinks to 2080 bits. A shortened cyclic code over those bits yields 32 check bits, which are appended to form a 2112-bit codeword. The whole codeword is then whitened with a pseudo-noise sequence and sent out as 32 words of 66 bits, so the line rate is unchanged.

The stream carries no back-pressure: there is no ready signal. The source must hold `in_valid` high for exactly 32 consecutive cycles per frame. Idle cycles may separate frames, or frames may follow back to back. The encoder answers each accepted block with exactly one output word at a fixed delay, so the downstream serializer always sees the same 32-cycle pattern, shifted in time.

Top module: `fire_fec_encoder`

## Requirements
- R1: The transcode bit of a block equals `in_block[1]`, and `in_block[0]` has no effect on the output.
- R2: The 65-bit transcoded block holds the transcode bit at position 0 and `in_block[k+1]` at position k for k = 1..64, except position 7, which holds `in_block[8]` XOR the transcode bit.
- R3: Serial codeword order: the transcoded block with in-frame index k occupies serial positions 65k to 65k+64, with bit i at position 65k+i. The in-frame index counts accepted blocks from 0 and restarts after 31.
- R4: The check bits come from shifting the 2080 serial bits, first position first, into a 32-bit register that is cleared at each frame start: feedback = bit XOR reg[31], reg shifts up by one, and when the feedback is 1 the mask 0x00A00805 is XORed in. Serial position 2080+i carries reg[31-i].
- R5: Output word j carries serial positions 66j+b at bit b, for b = 0..65.
- R6: Every serial position n is XORed with pn(n). A 58-bit register is set to all ones at each frame start; for each position, pn = reg[57] XOR reg[38], and the register then shifts up by one, taking pn in at bit 0.
- R7: `out_valid` equals `in_valid` delayed by 4 cycles. The word for the block accepted in cycle c appears in cycle c+4.
- R8: Each frame of 32 accepted blocks yields exactly 32 consecutive output words, including frames sent back to back.
- R9: Reset clears `out_valid` and restarts the in-frame index, so the first block accepted after reset is index 0.
- R10: While `in_valid` is low, `in_block` is ignored: no output word is produced, and later frames encode as if the idle data were never present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Block on `in_block` is accepted this cycle |
| in_block | input | 66 | Sync header in bits 1:0, payload in bits 65:2 |
| out_valid | output | 1 | `out_word` carries a codeword word |
| out_word | output | 66 | Scrambled codeword word, least significant bit first in serial order |

## Verification
The assertions check on every cycle that the fixed four-cycle delay holds between `in_valid` and `out_valid`, and that a run of output words always ends on a frame boundary. They also check that the repacking stage always sees two blocks of the same frame next to each other, that the check register stays unchanged while no block arrives, and that the first word of each frame is whitened by the all-ones-seeded sequence. Only the bench's scenarios can show that the bit-level content is right: the header squeeze, the bit-7 fold, the serial repacking across word boundaries, the check bits and the full whitening stream, compared against a model built from the requirements. Back-to-back frames, idle gaps with junk data, and a reset in the middle of a frame are also covered by the bench.

// File: rtl/fec_enc_pkg.sv
package fec_enc_pkg;
  parameter int BLK_W     = 66;
  parameter int TC_W      = BLK_W - 1;
  parameter int WORDS     = 32;
  parameter int IDX_W     = $clog2(WORDS);
  parameter int PAR_W     = 32;
  parameter int PN_W      = 58;
  parameter int PN_TAP    = 38;
  parameter int TC_FOLD   = 7;
  parameter logic [PAR_W-1:0] PAR_POLY = 32'h00A0_0805;

  typedef logic [TC_W-1:0]  tc_blk_t;
  typedef logic [PAR_W-1:0] par_t;
  typedef logic [PN_W-1:0]  pn_t;
  typedef logic [IDX_W-1:0] idx_t;

  // Divide one transcoded block into the running remainder, serial order.
  function automatic par_t par_step(input par_t r_in, input tc_blk_t d);
    par_t r;
    logic fb;
    r = r_in;
    for (int i = 0; i < TC_W; i++) begin
      fb = d[i] ^ r[PAR_W-1];
      r  = {r[PAR_W-2:0], 1'b0};
      if (fb) r = r ^ PAR_POLY;
    end
    return r;
  endfunction

  // Advance the whitening register by one output word; returns {state, bits}.
  function automatic logic [PN_W+BLK_W-1:0] pn_run(input pn_t s_in);
    pn_t s;
    logic [BLK_W-1:0] bits;
    s = s_in;
    for (int i = 0; i < BLK_W; i++) begin
      bits[i] = s[PN_W-1] ^ s[PN_TAP];
      s       = {s[PN_W-2:0], bits[i]};
    end
    return {s, bits};
  endfunction
endpackage

// File: rtl/fec_transcode.sv
module fec_transcode
  import fec_enc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [BLK_W-1:0] in_block,
  output logic             a_vld,
  output idx_t             a_idx,
  output tc_blk_t          a_blk
);
  localparam idx_t LAST = idx_t'(WORDS - 1);

  idx_t    cnt_q;
  tc_blk_t blk_c;
  logic    tbit;
  logic    unused_hdr;

  assign unused_hdr = in_block[0];

  always_comb begin
    tbit  = in_block[1];
    blk_c = {in_block[BLK_W-1:2], tbit};
    blk_c[TC_FOLD] = blk_c[TC_FOLD] ^ tbit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      a_vld <= 1'b0;
      a_idx <= '0;
      a_blk <= '0;
    end else begin
      a_vld <= in_valid;
      if (in_valid) begin
        a_idx <= cnt_q;
        a_blk <= blk_c;
        cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fec_parity.sv
module fec_parity
  import fec_enc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    a_vld,
  input  idx_t    a_idx,
  input  tc_blk_t a_blk,
  output par_t    par_q
);
  par_t seed;

  assign seed = (a_idx == '0) ? '0 : par_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) par_q <= '0;
    else if (a_vld) par_q <= par_step(seed, a_blk);
  end

  // R4: the remainder only moves when a block arrives
  p_parity_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !a_vld |=> $stable(par_q));
endmodule

// File: rtl/fec_repack.sv
module fec_repack
  import fec_enc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_vld,
  input  idx_t             a_idx,
  input  tc_blk_t          a_blk,
  input  par_t             par,
  output logic             w_vld,
  output idx_t             w_idx,
  output logic [BLK_W-1:0] w_data
);
  localparam idx_t LAST  = idx_t'(WORDS - 1);
  localparam int   POS_W = $clog2(TC_W);

  logic             b_vld;
  idx_t             b_idx;
  tc_blk_t          b_blk;
  tc_blk_t          nxt;
  logic [BLK_W-1:0] word_c;
  logic [POS_W-1:0] pos;

  always_comb begin
    nxt = '0;
    if (b_idx == LAST) begin
      for (int i = 0; i < PAR_W; i++) nxt[i] = par[PAR_W-1-i];
    end else begin
      nxt = a_blk;
    end
    for (int b = 0; b < BLK_W; b++) begin
      pos = POS_W'(b_idx) + POS_W'(b);
      if (int'(pos) < TC_W - 0 && (int'(b_idx) + b) < TC_W) word_c[b] = b_blk[pos];
      else word_c[b] = nxt[POS_W'(int'(b_idx) + b - TC_W)];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_vld  <= 1'b0;
      b_idx  <= '0;
      b_blk  <= '0;
      w_vld  <= 1'b0;
      w_idx  <= '0;
      w_data <= '0;
    end else begin
      b_vld <= a_vld;
      w_vld <= b_vld;
      if (a_vld) begin
        b_idx <= a_idx;
        b_blk <= a_blk;
      end
      if (b_vld) begin
        w_idx  <= b_idx;
        w_data <= word_c;
      end
    end
  end

  // R3: the two blocks stitched into one word are neighbours in one frame
  p_idx_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (b_vld && b_idx != LAST) |-> (a_vld && a_idx == b_idx + 1'b1));
endmodule

// File: rtl/fec_scramble.sv
module fec_scramble
  import fec_enc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             w_vld,
  input  idx_t             w_idx,
  input  logic [BLK_W-1:0] w_data,
  output logic             out_valid,
  output logic [BLK_W-1:0] out_word
);
  localparam logic [PN_W+BLK_W-1:0] FIRST_RUN = pn_run('1);
  localparam logic [BLK_W-1:0]      PN_FIRST  = FIRST_RUN[BLK_W-1:0];

  pn_t                   pn_q;
  pn_t                   seed;
  logic [PN_W+BLK_W-1:0] run;

  assign seed = (w_idx == '0) ? '1 : pn_q;
  assign run  = pn_run(seed);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pn_q      <= '1;
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= w_vld;
      if (w_vld) begin
        out_word <= w_data ^ run[BLK_W-1:0];
        pn_q     <= run[PN_W+BLK_W-1:BLK_W];
      end
    end
  end

  // R6: word 0 of every frame is whitened by the all-ones-seeded sequence
  p_pn_seed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (w_vld && w_idx == '0) |=> ((out_word ^ $past(w_data)) == PN_FIRST));
endmodule

// File: rtl/fire_fec_encoder.sv
module fire_fec_encoder
  import fec_enc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [BLK_W-1:0] in_block,
  output logic             out_valid,
  output logic [BLK_W-1:0] out_word
);
  logic             a_vld;
  idx_t             a_idx;
  tc_blk_t          a_blk;
  par_t             par_q;
  logic             w_vld;
  idx_t             w_idx;
  logic [BLK_W-1:0] w_data;

  fec_transcode u_tc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_block(in_block),
    .a_vld(a_vld), .a_idx(a_idx), .a_blk(a_blk));

  fec_parity u_par (
    .clk(clk), .rst_n(rst_n), .a_vld(a_vld), .a_idx(a_idx), .a_blk(a_blk),
    .par_q(par_q));

  fec_repack u_pack (
    .clk(clk), .rst_n(rst_n), .a_vld(a_vld), .a_idx(a_idx), .a_blk(a_blk),
    .par(par_q), .w_vld(w_vld), .w_idx(w_idx), .w_data(w_data));

  fec_scramble u_scr (
    .clk(clk), .rst_n(rst_n), .w_vld(w_vld), .w_idx(w_idx), .w_data(w_data),
    .out_valid(out_valid), .out_word(out_word));

  // Cycles since reset (saturating) and output-run position, for the checks below
  logic [2:0] age_q;
  idx_t       orun_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q  <= '0;
      orun_q <= '0;
    end else begin
      if (age_q != 3'd4) age_q <= age_q + 3'd1;
      if (out_valid) orun_q <= (orun_q == idx_t'(WORDS - 1)) ? '0 : orun_q + 1'b1;
    end
  end

  // R7: fixed four-cycle delay from accepted block to output word
  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 3'd4) |-> (out_valid == $past(in_valid, 4)));

  // R8: a run of output words only ends on a frame boundary
  p_frame_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> (orun_q == '0));
endmodule

// File: tb/tb_fire_fec_encoder.sv
`timescale 1ns/1ps
module tb_fire_fec_encoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [65:0] in_block = '0;
  logic        out_valid;
  logic [65:0] out_word;

  fire_fec_encoder dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_block(in_block),
    .out_valid(out_valid), .out_word(out_word));

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int nout   = 0;
  int nframes = 0;
  bit mon_en = 1'b0;
  bit done   = 1'b0;

  logic [65:0] frm [32];
  logic [65:0] exp_q [$];
  int          t0_q [$];
  string       lbl_q [$];
  string       cur_lbl = "";
  int          midx = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [65:0] act, input logic [65:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // Model of R1..R6, built straight from the requirement text
  task automatic push_expected();
    logic [2111:0] ser;
    logic [31:0]   r;
    logic [57:0]   s;
    logic          t, fb, pn;
    logic [65:0]   w;
    for (int k = 0; k < 32; k++) begin
      t = frm[k][1];
      ser[65*k] = t;
      for (int i = 1; i < 65; i++)
        ser[65*k+i] = frm[k][i+1] ^ ((i == 7) ? t : 1'b0);
    end
    r = '0;
    for (int n = 0; n < 2080; n++) begin
      fb = ser[n] ^ r[31];
      r  = {r[30:0], 1'b0};
      if (fb) r = r ^ 32'h00A00805;
    end
    for (int i = 0; i < 32; i++) ser[2080+i] = r[31-i];
    s = '1;
    for (int n = 0; n < 2112; n++) begin
      pn = s[57] ^ s[38];
      s  = {s[56:0], pn};
      ser[n] = ser[n] ^ pn;
    end
    for (int j = 0; j < 32; j++) begin
      for (int b = 0; b < 66; b++) w[b] = ser[66*j+b];
      exp_q.push_back(w);
    end
  endtask

  task automatic send_frame(input string lbl);
    push_expected();
    lbl_q.push_back(lbl);
    nframes++;
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      if (k == 0) t0_q.push_back(cyc);
      in_valid = 1'b1;
      in_block = frm[k];
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_block = 66'({$urandom(), $urandom(), $urandom()});
    end
  endtask

  function automatic logic [65:0] rnd66();
    return 66'({$urandom(), $urandom(), $urandom()});
  endfunction

  // Monitor
  always @(negedge clk) begin
    if (mon_en && out_valid) begin
      logic [65:0] e;
      nout++;
      if (midx == 0) begin
        int t0;
        cur_lbl = (lbl_q.size() != 0) ? lbl_q.pop_front() : "none";
        t0 = (t0_q.size() != 0) ? t0_q.pop_front() : -100;
        chk(cyc == t0 + 4, {"R7 latency ", cur_lbl}, 66'(cyc), 66'(t0 + 4));
      end
      e = (exp_q.size() != 0) ? exp_q.pop_front() : 'x;
      chk(out_word === e, $sformatf("R5 R6 word %0d of %s", midx, cur_lbl), out_word, e);
      midx = (midx == 31) ? 0 : midx + 1;
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R9 reset out_valid", 66'(out_valid), 66'd0);
    rst_n = 1'b1;
    mon_en = 1'b1;
    idle(3);

    // R4 R6: all-zero frame gives pure whitening plus zero check bits
    for (int k = 0; k < 32; k++) frm[k] = '0;
    send_frame("R4 R6 all-zero frame");
    idle(5);

    // R1: control-style headers, bit 0 random (must not matter)
    for (int k = 0; k < 32; k++) frm[k] = {rnd66() >> 2, 1'b0, 1'($urandom())};
    send_frame("R1 header bit0 ignored");
    idle(2);

    // R2: data headers with bit 8 toggling to exercise the fold
    for (int k = 0; k < 32; k++) begin
      frm[k] = rnd66();
      frm[k][1] = 1'b1;
      frm[k][8] = k[0];
    end
    send_frame("R2 fold into bit 7");
    idle(1);

    // R3 R8: back-to-back random frames
    for (int f = 0; f < 3; f++) begin
      for (int k = 0; k < 32; k++) frm[k] = rnd66();
      send_frame($sformatf("R3 R8 back-to-back %0d", f));
    end

    // R10: idle gap with junk data
    idle(9);
    chk(out_valid == 1'b0, "R10 idle no output", 66'(out_valid), 66'd0);
    for (int k = 0; k < 32; k++) frm[k] = {66{1'b1}};
    send_frame("R10 all-ones after junk");
    idle(8);

    // R9: reset in the middle of a frame
    @(negedge clk);
    mon_en = 1'b0;
    for (int k = 0; k < 10; k++) begin
      in_valid = 1'b1;
      in_block = rnd66();
      @(negedge clk);
    end
    rst_n = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 reset mid-frame", 66'(out_valid), 66'd0);
    rst_n = 1'b1;
    midx = 0;
    @(negedge clk);
    mon_en = 1'b1;
    for (int k = 0; k < 32; k++) frm[k] = rnd66();
    send_frame("R9 first frame after reset");

    for (int f = 0; f < 3; f++) begin
      idle(f);
      for (int k = 0; k < 32; k++) frm[k] = rnd66();
      send_frame($sformatf("R3 R5 random %0d", f));
    end
    idle(12);

    chk(exp_q.size() == 0, "R8 all words delivered", 66'(exp_q.size()), 66'd0);
    chk(nout == 32 * (nframes), "R8 word count", 66'(nout), 66'(32 * nframes));
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule